// File: doc/BRIEF.md
# I2C Slave Command-Reservation Responder

This block is a byte-level I2C slave whose next action is fixed beforehand by one 8-bit reservation command. Software writes the command, then the engine meets the next bus transaction on its own: it recognises its 7-bit address, answers with the preset acknowledge or not-acknowledge, and either collects written bytes into a one- or two-entry receive buffer or sends bytes taken from `tx_data_i`. For reads, the command also selects what happens when the master refuses a byte.

The open-drain line is modelled as an enable: while `sda_oe_o` is high the surrounding pad pulls SDA low, and otherwise SDA is released. Both bus inputs pass through a two-flop synchronizer before any edge is detected. The slave never stretches SCL.

Top module: `i2c_resv_slave`

## Requirements
- R1: Command 0x00 disables the engine: `sda_oe_o` stays low, no byte is stored and no status flag is raised by bus traffic.
- R2: Writing any command other than 0x00 and 0xA0–0xAB (for example 0xAC–0xAF) sets `cmd_err_o`, and the engine then behaves as disabled. Valid commands leave `cmd_err_o` low.
- R3: After a START, the first byte is taken MSB first. Bits 7:1 are compared with `own_addr_i` and bit 0 is R/W (1 = read). On a match `addr_hit_o` is set and `rw_o` holds the R/W bit.
- R4: On an address mismatch the slave acknowledges nothing and stores nothing until the next START.
- R5: Commands 0xA0 and 0xA2 acknowledge a matching address. Commands 0xA1 and 0xA3 answer it with NAK (SDA released) and ignore the rest of that transaction.
- R6: Written data bytes are acknowledged under 0xA0–0xA3 and 0xA8–0xAB. Under 0xA4–0xA7, command bit 0 picks the reply: 0 gives ACK, 1 gives NAK.
- R7: Under 0xA0–0xA7, command bit 1 picks the buffer capacity: 0 gives one byte, 1 gives two. 0xA8–0xAB use one byte. A byte that arrives while the buffer is full is dropped, is answered with NAK and sets `overrun_o`. Stored bytes leave in arrival order on `rx_data_o` when `rx_valid_o` is high and `rx_pop_i` is pulsed.
- R8: In a read, each byte is sampled from `tx_data_i` at the SCL falling edge that ends the previous acknowledge bit, and it is driven MSB first.
- R9: Under 0xA8, 0xAA and 0xA0–0xA7, a master NAK sets `nak_seen_o`, and the slave then releases SDA until the next START or STOP.
- R10: Under 0xA9 and 0xAB, a master NAK sets `nak_seen_o`, and the slave still loads and sends the next byte.
- R11: A STOP seen while the engine is enabled releases SDA, returns the engine to idle and sets `stop_seen_o`.
- R12: Every command write clears `addr_hit_o`, `stop_seen_o`, `nak_seen_o` and `overrun_o`.
- R13: The slave starts pulling SDA only while the synchronized SCL is low, so data it drives is stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Write strobe for the reservation command |
| cmd_i | input | 8 | Reservation command value |
| own_addr_i | input | ADDR_W | Own 7-bit slave address |
| tx_data_i | input | DW | Byte to send in read transfers |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | High pulls SDA low |
| rx_data_o | output | DW | Oldest received byte |
| rx_valid_o | output | 1 | Receive buffer holds a byte |
| rx_pop_i | input | 1 | Removes the oldest received byte |
| addr_hit_o | output | 1 | Own address was seen |
| rw_o | output | 1 | R/W bit of the matched address |
| stop_seen_o | output | 1 | STOP detected |
| nak_seen_o | output | 1 | Master returned NAK during a read |
| overrun_o | output | 1 | A received byte was dropped |
| cmd_err_o | output | 1 | Last command was a reserved code |

## Verification
The bench builds the block with its defaults: a 7-bit address, 8-bit data, a two-stage synchronizer and a two-entry receive buffer. With a buffer only two deep, sending one to three bytes in every slave receive command reaches both the capacity limit and the overrun path. The address and data reply bits are checked for every such command. All 256 command values are swept against the reserved-code rule. Every transmit command is run through ACK, NAK and continue-after-NAK reads.

// File: rtl/i2c_resv_pkg.sv
package i2c_resv_pkg;
    localparam int CMD_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } eng_state_e;

    // decoded behaviour of one reservation command
    typedef struct packed {
        logic active;    // engine takes part in bus traffic
        logic reserved;  // code outside the legal set
        logic addr_nak;  // answer own address with NAK
        logic data_nak;  // answer data bytes with NAK
        logic dbl_buf;   // two-entry receive buffer
        logic tx_halt;   // stop sending after a master NAK
    } cmd_cfg_t;
endpackage

// File: rtl/i2c_resv_sync.sv
module i2c_resv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign q_o    = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_resv_cmd_decode.sv
module i2c_resv_cmd_decode
    import i2c_resv_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    output cmd_cfg_t         cfg_o
);
    always_comb begin
        cfg_o = '0;
        if (cmd_i == '0) begin
            cfg_o = '0;
        end else if (cmd_i[7:4] == 4'hA && cmd_i[3:0] <= 4'hB) begin
            cfg_o.active = 1'b1;
            unique case (cmd_i[3:2])
                2'b00: begin
                    cfg_o.addr_nak = cmd_i[0];
                    cfg_o.dbl_buf  = cmd_i[1];
                    cfg_o.tx_halt  = 1'b1;
                end
                2'b01: begin
                    cfg_o.data_nak = cmd_i[0];
                    cfg_o.dbl_buf  = cmd_i[1];
                    cfg_o.tx_halt  = 1'b1;
                end
                default: begin
                    cfg_o.tx_halt  = ~cmd_i[0];
                end
            endcase
        end else begin
            cfg_o.reserved = 1'b1;
        end
    end
endmodule

// File: rtl/i2c_resv_rxbuf.sv
module i2c_resv_rxbuf #(
    parameter int DW    = 8,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbl_i,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic          full_o,
    output logic          valid_o,
    output logic [DW-1:0] head_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [CW-1:0]            cnt;
    } buf_t;

    buf_t          q, d;
    logic [CW-1:0] cap;
    logic [CW-1:0] cnt_mid;

    assign cap = dbl_i ? CW'(DEPTH) : CW'(1);

    always_comb begin
        d       = q;
        cnt_mid = q.cnt;
        if (pop_i && q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                d.mem[i] = q.mem[i+1];
            end
            cnt_mid = q.cnt - 1'b1;
        end
        if (push_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == cnt_mid) d.mem[i] = push_data_i;
            end
            cnt_mid = cnt_mid + 1'b1;
        end
        d.cnt = cnt_mid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full_o  = (q.cnt >= cap);
    assign valid_o = (q.cnt != '0);
    assign head_o  = q.mem[0];
endmodule

// File: rtl/i2c_resv_slave.sv
module i2c_resv_slave
    import i2c_resv_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RX_DEPTH    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [DW-1:0]     tx_data_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    output logic [DW-1:0]     rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_pop_i,
    output logic              addr_hit_o,
    output logic              rw_o,
    output logic              stop_seen_o,
    output logic              nak_seen_o,
    output logic              overrun_o,
    output logic              cmd_err_o
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(DW);

    typedef struct packed {
        eng_state_e       st;
        logic [CMD_W-1:0] cmd;
        logic [DW-1:0]    sh;
        logic [CNT_W-1:0] cnt;
        logic             oe;
        logic             mnak;
        logic             addr_hit;
        logic             rw;
        logic             stop_seen;
        logic             nak_seen;
        logic             overrun;
        logic             cmd_err;
    } eng_t;

    eng_t             q, n;
    logic             scl_s, scl_rise, scl_fall;
    logic             sda_s, sda_rise, sda_fall;
    logic             start_det, stop_det;
    logic [CMD_W-1:0] cmd_eff;
    cmd_cfg_t         cfg;
    logic             eng_active;
    logic             push, buf_full;

    i2c_resv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i),
        .q_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2c_resv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i),
        .q_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    assign start_det = sda_fall & scl_s;
    assign stop_det  = sda_rise & scl_s;

    // a command written this cycle takes effect at once
    assign cmd_eff = cmd_wr_i ? cmd_i : q.cmd;

    i2c_resv_cmd_decode u_dec (
        .cmd_i(cmd_eff),
        .cfg_o(cfg)
    );

    assign eng_active = cfg.active;

    i2c_resv_rxbuf #(.DW(DW), .DEPTH(RX_DEPTH)) u_rxbuf (
        .clk(clk), .rst_n(rst_n),
        .dbl_i(cfg.dbl_buf),
        .push_i(push), .push_data_i(q.sh),
        .pop_i(rx_pop_i),
        .full_o(buf_full), .valid_o(rx_valid_o), .head_o(rx_data_o)
    );

    always_comb begin
        n    = q;
        push = 1'b0;

        if (!cfg.active) begin
            n.st = ST_IDLE;
            n.oe = 1'b0;
        end else if (start_det) begin
            n.st  = ST_ADDR;
            n.cnt = '0;
            n.oe  = 1'b0;
        end else if (stop_det) begin
            n.st        = ST_IDLE;
            n.oe        = 1'b0;
            n.stop_seen = 1'b1;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[DW-2:0], sda_s};
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BYTE_END) begin
                        if (q.sh[DW-1 -: ADDR_W] == own_addr_i) begin
                            n.addr_hit = 1'b1;
                            n.rw       = q.sh[0];
                            if (cfg.addr_nak) begin
                                n.st = ST_SKIP;
                            end else begin
                                n.oe = 1'b1;
                                n.st = ST_ADDR_ACK;
                            end
                        end else begin
                            n.st = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.rw) begin
                            n.sh = tx_data_i;
                            n.oe = ~tx_data_i[DW-1];
                            n.st = ST_TX;
                        end else begin
                            n.oe = 1'b0;
                            n.st = ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[DW-2:0], sda_s};
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BYTE_END) begin
                        if (!buf_full) begin
                            push = 1'b1;
                            n.oe = ~cfg.data_nak;
                        end else begin
                            n.overrun = 1'b1;
                            n.oe      = 1'b0;
                        end
                        n.st = ST_RX_ACK;
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.cnt = '0;
                        n.st  = ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == BYTE_END) begin
                            n.oe = 1'b0;
                            n.st = ST_TX_ACK;
                        end else begin
                            n.sh = {q.sh[DW-2:0], 1'b0};
                            n.oe = ~q.sh[DW-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        n.mnak = sda_s;
                    end else if (scl_fall) begin
                        if (q.mnak) n.nak_seen = 1'b1;
                        if (q.mnak && cfg.tx_halt) begin
                            n.oe = 1'b0;
                            n.st = ST_SKIP;
                        end else begin
                            n.sh  = tx_data_i;
                            n.oe  = ~tx_data_i[DW-1];
                            n.cnt = '0;
                            n.st  = ST_TX;
                        end
                    end
                end
                default: begin
                    n.oe = 1'b0;
                end
            endcase
        end

        if (cmd_wr_i) begin
            n.cmd       = cmd_i;
            n.addr_hit  = 1'b0;
            n.stop_seen = 1'b0;
            n.nak_seen  = 1'b0;
            n.overrun   = 1'b0;
            n.cmd_err   = cfg.reserved;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_oe_o    = q.oe;
    assign addr_hit_o  = q.addr_hit;
    assign rw_o        = q.rw;
    assign stop_seen_o = q.stop_seen;
    assign nak_seen_o  = q.nak_seen;
    assign overrun_o   = q.overrun;
    assign cmd_err_o   = q.cmd_err;
endmodule

// File: rtl/i2c_resv_slave_chk.sv
module i2c_resv_slave_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sda_oe,
    input logic          scl_s,
    input logic          stop_det,
    input logic          active,
    input logic          cmd_wr,
    input logic [7:0]    cmd,
    input logic          cmd_err,
    input logic          stop_seen,
    input logic          rx_valid,
    input logic          rx_pop,
    input logic [DW-1:0] rx_data
);
    // R1 and R2: a disabled or reserved command never touches the bus
    p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sda_oe);

    p_reserved_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd != 8'h00 && !(cmd >= 8'hA0 && cmd <= 8'hAB)) |=> cmd_err);

    p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && active && !cmd_wr) |=> (!sda_oe && stop_seen));

    p_drive_on_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    p_head_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_pop) |=> (rx_valid && $stable(rx_data)));
endmodule

bind i2c_resv_slave i2c_resv_slave_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_s(scl_s),
    .stop_det(stop_det), .active(eng_active), .cmd_wr(cmd_wr_i), .cmd(cmd_i),
    .cmd_err(cmd_err_o), .stop_seen(stop_seen_o), .rx_valid(rx_valid_o),
    .rx_pop(rx_pop_i), .rx_data(rx_data_o)
);

// File: tb/test_i2c_resv_slave.sv
module test_i2c_resv_slave;
    localparam int H = 8;
    localparam logic [6:0] OWN = 7'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic [7:0] tx_data = 8'h00;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       rx_pop = 1'b0;
    logic       sda_oe, rx_valid, addr_hit, rw, stop_seen, nak_seen, overrun, cmd_err;
    logic [7:0] rx_data;
    wire        sda_line = m_sda & ~sda_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    i2c_resv_slave i_i2c_resv_slave (
        .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_i(cmd),
        .own_addr_i(OWN), .tx_data_i(tx_data), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
        .rx_pop_i(rx_pop), .addr_hit_o(addr_hit), .rw_o(rw),
        .stop_seen_o(stop_seen), .nak_seen_o(nak_seen), .overrun_o(overrun),
        .cmd_err_o(cmd_err)
    );

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcmd(input logic [7:0] c);
        cmd = c; cmd_wr = 1'b1; tick(1); cmd_wr = 1'b0; tick(2);
    endtask

    task automatic m_start();
        m_scl = 1'b1; m_sda = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(H);
    endtask

    task automatic rbit(output logic b);
        logic s1;
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(2);
        s1 = sda_line; tick(H - 2);
        b = sda_line;
        chk("R13 SDA stable while SCL high", b, s1);
        m_scl = 1'b0; tick(H);
    endtask

    // returns 1 when the slave acknowledged
    task automatic wbyte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(a);
        acked = ~a;
    endtask

    task automatic rbyte(input logic nak, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(nak);
    endtask

    function automatic logic [7:0] dat(input logic [7:0] c, input int k, input int mm);
        return 8'(c * 7 + k * 53 + mm);
    endfunction

    logic [7:0] wcmds [0:10] = '{8'h00, 8'hAC, 8'hAF, 8'hA0, 8'hA1, 8'hA2,
                                 8'hA3, 8'hA4, 8'hA5, 8'hA6, 8'hA7};
    logic [7:0] rcmds [0:4]  = '{8'hA8, 8'hA9, 8'hAA, 8'hAB, 8'hA0};

    initial begin
        logic       ack;
        logic [7:0] rd;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        chk("R1 reset sda_oe", sda_oe, 0);
        chk("R7 reset rx_valid", rx_valid, 0);
        chk("R3 reset addr_hit", addr_hit, 0);
        chk("R2 reset cmd_err", cmd_err, 0);

        // R2: every command value
        for (int c = 0; c < 256; c++) begin
            logic legal;
            legal = (c == 0) || (c >= 8'hA0 && c <= 8'hAB);
            wcmd(8'(c));
            chk("R2 reserved flag", cmd_err, !legal);
        end

        // write transactions
        for (int i = 0; i < 11; i++) begin
            for (int mm = 0; mm < 2; mm++) begin
                for (int nb = 1; nb <= 3; nb++) begin
                    logic [7:0] c;
                    logic act, aack, dnak;
                    int cap, nst;
                    if (mm == 1 && nb > 1) continue;
                    c = wcmds[i];
                    wcmd(c);
                    chk("R12 stop flag cleared", stop_seen, 0);
                    chk("R12 overrun cleared", overrun, 0);
                    act  = (c != 8'h00) && (c[7:4] == 4'hA) && (c[3:0] <= 4'hB);
                    aack = act && (mm == 0) && !(c[3:2] == 2'b00 && c[0]);
                    dnak = c[2] & c[0];
                    cap  = c[1] ? 2 : 1;
                    m_start();
                    wbyte({(mm == 1) ? (OWN ^ 7'h01) : OWN, 1'b0}, ack);
                    chk("R5 address reply", ack, aack);
                    chk("R3 R4 addr_hit", addr_hit, act && (mm == 0));
                    if (c == 8'h00) chk("R1 disabled no hit", addr_hit, 0);
                    chk("R3 rw latched", rw, 0);
                    for (int k = 0; k < nb; k++) begin
                        wbyte(dat(c, k, mm), ack);
                        chk("R6 R7 data reply", ack, aack && (k < cap) && !dnak);
                    end
                    m_stop();
                    chk("R11 stop flag", stop_seen, act);
                    chk("R11 released after stop", sda_oe, 0);
                    chk("R7 overrun", overrun, aack && (nb > cap));
                    nst = aack ? ((nb < cap) ? nb : cap) : 0;
                    for (int j = 0; j < nst; j++) begin
                        chk("R7 stored valid", rx_valid, 1);
                        chk("R7 stored order", rx_data, dat(c, j, mm));
                        rx_pop = 1'b1; tick(1); rx_pop = 1'b0; tick(1);
                    end
                    chk("R4 R1 nothing extra stored", rx_valid, 0);
                end
            end
        end

        // read transactions
        for (int i = 0; i < 5; i++) begin
            logic [7:0] c, b0, b1, b2;
            logic halt;
            c  = rcmds[i];
            b0 = 8'hC3 ^ c;
            b1 = 8'h3C + c;
            b2 = 8'h81 ^ c;
            halt = !(c == 8'hA9 || c == 8'hAB);
            wcmd(c);
            chk("R12 nak flag cleared", nak_seen, 0);
            tx_data = b0;
            m_start();
            wbyte({OWN, 1'b1}, ack);
            chk("R8 read address ack", ack, 1);
            chk("R3 rw read", rw, 1);
            tx_data = b1;
            rbyte(1'b0, rd);
            chk("R8 first byte", rd, b0);
            chk("R8 no nak yet", nak_seen, 0);
            tx_data = b2;
            rbyte(1'b1, rd);
            chk("R8 second byte", rd, b1);
            chk("R9 R10 nak flag", nak_seen, 1);
            tx_data = 8'hFF;
            rbyte(1'b1, rd);
            if (halt) chk("R9 released after nak", rd, 8'hFF);
            else      chk("R10 continues after nak", rd, b2);
            m_stop();
            chk("R11 stop after read", stop_seen, 1);
            chk("R11 idle release", sda_oe, 0);
        end

        wcmd(8'h00);
        chk("R12 final clear", addr_hit, 0);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule